// File: doc/BRIEF.md
# Remote update status and retry tracker

This block holds the remote-update bookkeeping for a device that can boot from any of several images stored in flash. A mailbox front end hands it decoded commands: an image-update command that names the flash offset of the next image, a status query, and a notify command that clears parts of the state. A configuration engine drives three single-cycle event inputs: a configuration succeeded, a configuration failed, and a retry was attempted.

The block keeps six things: the offset of the running image, the offset of the first image that failed, the failure code, the error location and detail words of that failure, and a retry count for the running image. A failure record is kept through ordinary reconfiguration. It is cleared in two cases only: a successful boot that follows an image-update command, or an explicit notify code. When the retry count reaches its limit, the block raises a fallback request toward the factory image and the count stops rising.

Each accepted command returns a response. The response is a header word, plus nine data words for the status query. For an image-update command, the reconfiguration request is issued only after the host has taken the whole response.

Top module: `rsu_status_tracker`

## Requirements
- R1: After reset, the current offset, failing offset, failure code, error location, error detail and retry count are all zero. `fallback_req`, `reconfig_req` and `rsp_valid` are low, and `cmd_ready` is high.
- R2: Opcode 0x5B returns a header and then nine data words, in this order: 0 (upper current offset), current offset, 0 (upper failing offset), failing offset, failure code, `VERSION`, error location, error detail, retry count. The header has bit 31 = error, bits [23:16] = opcode echo, bits [3:0] = number of data words, and all other bits zero. For this opcode the header is error 0 with length 9.
- R3: Opcode 0x5C returns an OK header of length 0. The target offset is `cmd_arg0` when `cmd_argc` is at least 1, and zero when no argument is given. `reconfig_req` pulses for one cycle, in the cycle after the response header is handed over, with `reconfig_addr` equal to the target.
- R4: A `cfg_ok` that follows an issued image-update sets the current offset to the target. It also clears the failing offset, failure code, location, detail, retry count and `fallback_req`. A `cfg_ok` with no image-update pending changes nothing.
- R5: A `cfg_fail` while the failing offset is zero records the current offset together with `cfg_code`, `cfg_loc` and `cfg_detail`. Further failures leave the record unchanged.
- R6: Each `cfg_retry` raises the retry count by one, up to `MAX_RETRY`-1. A retry that arrives at that limit sets `fallback_req` and leaves the count unchanged.
- R7: Notify (0x5D) with argument 0x00050000 clears the retry count and `fallback_req`, and returns an OK header of length 0.
- R8: Notify with argument 0x00060000 clears the failing offset, failure code, location and detail, and leaves the retry count unchanged.
- R9: Each of the following returns an error header (bit 31 set, length 0) and changes no state: a notify with any other argument, including a notify with no argument; an image-update with a nonzero upper argument word (this also issues no `reconfig_req`); an unknown opcode.
- R10: `cmd_ready` is low while a response is outstanding. A response word offered while `rsp_ready` is low stays offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 8 | Command opcode |
| cmd_argc | input | 2 | Number of argument words supplied |
| cmd_arg0 | input | 32 | First argument word (low half of the update offset) |
| cmd_arg1 | input | 32 | Second argument word (high half of the update offset) |
| rsp_valid | output | 1 | Response word offered |
| rsp_ready | input | 1 | Host takes the response word |
| rsp_word | output | 32 | Response word |
| rsp_last | output | 1 | Last word of the response |
| cfg_ok | input | 1 | Configuration succeeded (pulse) |
| cfg_fail | input | 1 | Configuration failed (pulse) |
| cfg_retry | input | 1 | Retry attempted (pulse) |
| cfg_code | input | 32 | Failure code for `cfg_fail` |
| cfg_loc | input | 32 | Error location for `cfg_fail` |
| cfg_detail | input | 32 | Error detail for `cfg_fail` |
| reconfig_req | output | 1 | Start reconfiguration (pulse) |
| reconfig_addr | output | 32 | Flash offset to configure from |
| fallback_req | output | 1 | Retry limit reached; boot the factory image |

## Verification
The assertions check these properties on every cycle:
- the retry count never exceeds its limit;
- a fallback request rises only after a retry event;
- a nonzero failure record changes only by being cleared to zero;
- a reconfiguration pulse comes only right after the final response word is handed over;
- a stalled response word stays offered.

Only the bench scenarios can show the rest:
- the exact word order of the status response;
- that a plain successful boot keeps the failure record;
- that only the first failure is kept;
- what each notify code clears;
- that reserved arguments leave every field unchanged.

// File: rtl/rsu_status_tracker.sv
module rsu_status_tracker #(
  parameter int          MAX_RETRY = 3,
  parameter logic [31:0] VERSION   = 32'h0000_0202
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [7:0]  cmd_op,
  input  logic [1:0]  cmd_argc,
  input  logic [31:0] cmd_arg0,
  input  logic [31:0] cmd_arg1,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_word,
  output logic        rsp_last,
  input  logic        cfg_ok,
  input  logic        cfg_fail,
  input  logic        cfg_retry,
  input  logic [31:0] cfg_code,
  input  logic [31:0] cfg_loc,
  input  logic [31:0] cfg_detail,
  output logic        reconfig_req,
  output logic [31:0] reconfig_addr,
  output logic        fallback_req
);
  localparam logic [1:0]  LIM       = 2'(MAX_RETRY - 1);
  localparam logic [7:0]  OP_UPD    = 8'h5C;
  localparam logic [7:0]  OP_STAT   = 8'h5B;
  localparam logic [7:0]  OP_NOTE   = 8'h5D;
  localparam logic [31:0] N_RETRY   = 32'h0005_0000;
  localparam logic [31:0] N_ERRCLR  = 32'h0006_0000;

  logic [31:0] cur_off, fail_off, f_code, f_loc, f_det, tgt;
  logic [1:0]  retry;
  logic        busy, r_err, r_upd, pend;
  logic [7:0]  r_op;
  logic [3:0]  idx, len;
  logic [31:0] data_w;

  wire accept = cmd_valid && cmd_ready;
  wire [31:0] a0 = (cmd_argc != 2'd0) ? cmd_arg0 : 32'h0;
  wire [31:0] a1 = cmd_argc[1] ? cmd_arg1 : 32'h0;
  wire xfer = rsp_valid && rsp_ready;

  assign cmd_ready     = !busy;
  assign rsp_valid     = busy;
  assign rsp_last      = busy && (idx == len);
  assign reconfig_addr = tgt;

  always_comb begin
    case (idx)
      4'd2:    data_w = cur_off;
      4'd4:    data_w = fail_off;
      4'd5:    data_w = f_code;
      4'd6:    data_w = VERSION;
      4'd7:    data_w = f_loc;
      4'd8:    data_w = f_det;
      4'd9:    data_w = {30'h0, retry};
      default: data_w = 32'h0;
    endcase
  end

  assign rsp_word = (idx == 4'd0) ? {r_err, 7'h0, r_op, 12'h0, len} : data_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_off <= '0; fail_off <= '0; f_code <= '0; f_loc <= '0; f_det <= '0;
      tgt <= '0; retry <= '0; fallback_req <= 1'b0; pend <= 1'b0;
      busy <= 1'b0; r_err <= 1'b0; r_upd <= 1'b0; r_op <= '0;
      idx <= '0; len <= '0; reconfig_req <= 1'b0;
    end else begin
      reconfig_req <= 1'b0;
      if (cfg_ok && pend) begin
        cur_off <= tgt; fail_off <= '0; f_code <= '0; f_loc <= '0; f_det <= '0;
        retry <= '0; fallback_req <= 1'b0; pend <= 1'b0;
      end else if (cfg_fail && fail_off == 32'h0) begin
        fail_off <= cur_off; f_code <= cfg_code; f_loc <= cfg_loc; f_det <= cfg_detail;
      end
      if (cfg_retry) begin
        if (retry >= LIM) fallback_req <= 1'b1;
        else              retry <= retry + 2'd1;
      end
      if (xfer) begin
        if (idx == len) begin
          busy <= 1'b0;
          if (r_upd) begin
            reconfig_req <= 1'b1;
            pend         <= 1'b1;
          end
          r_upd <= 1'b0;
        end else begin
          idx <= idx + 4'd1;
        end
      end
      if (accept) begin
        busy  <= 1'b1;
        idx   <= '0;
        r_op  <= cmd_op;
        r_err <= 1'b0;
        len   <= 4'd0;
        r_upd <= 1'b0;
        case (cmd_op)
          OP_STAT: len <= 4'd9;
          OP_UPD: begin
            if (a1 != 32'h0) r_err <= 1'b1;
            else begin
              tgt   <= a0;
              r_upd <= 1'b1;
            end
          end
          OP_NOTE: begin
            if (a0 == N_RETRY) begin
              retry        <= '0;
              fallback_req <= 1'b0;
            end else if (a0 == N_ERRCLR) begin
              fail_off <= '0; f_code <= '0; f_loc <= '0; f_det <= '0;
            end else begin
              r_err <= 1'b1;
            end
          end
          default: r_err <= 1'b1;
        endcase
      end
    end
  end

  p_retry_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    retry <= LIM);

  p_fallback_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fallback_req) |-> $past(cfg_retry));

  p_first_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fail_off) != 32'h0 && fail_off != $past(fail_off)) |-> fail_off == 32'h0);

  p_reconfig_after_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig_req |-> $past(rsp_valid && rsp_ready && rsp_last));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid);

  p_accept_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (rsp_valid && !cmd_ready));
endmodule

// File: tb/rsu_status_tracker_test.sv
module rsu_status_tracker_test;
  localparam logic [31:0] VER = 32'h0000_0303;
  localparam int          MR  = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, rsp_ready = 1'b0;
  logic [7:0] cmd_op = '0;
  logic [1:0] cmd_argc = '0;
  logic [31:0] cmd_arg0 = '0, cmd_arg1 = '0;
  logic cfg_ok = 1'b0, cfg_fail = 1'b0, cfg_retry = 1'b0;
  logic [31:0] cfg_code = '0, cfg_loc = '0, cfg_detail = '0;
  logic cmd_ready, rsp_valid, rsp_last, reconfig_req, fallback_req;
  logic [31:0] rsp_word, reconfig_addr;

  rsu_status_tracker #(.MAX_RETRY(MR), .VERSION(VER)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_argc(cmd_argc), .cmd_arg0(cmd_arg0), .cmd_arg1(cmd_arg1),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_word(rsp_word), .rsp_last(rsp_last),
    .cfg_ok(cfg_ok), .cfg_fail(cfg_fail), .cfg_retry(cfg_retry),
    .cfg_code(cfg_code), .cfg_loc(cfg_loc), .cfg_detail(cfg_detail),
    .reconfig_req(reconfig_req), .reconfig_addr(reconfig_addr), .fallback_req(fallback_req));

  int n_chk = 0, n_fail = 0;
  logic [31:0] q_word[$];
  logic        q_last[$];
  logic        q_rc[$];
  string       q_tag[$];
  logic [31:0] m_cur = 0, m_fail = 0, m_code = 0, m_loc = 0, m_det = 0, m_tgt = 0;
  logic [1:0]  m_retry = 0;
  logic        m_fb = 0, m_pend = 0;
  logic        rc_due = 0;
  logic        mon_on = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic err, input logic [7:0] op, input logic [3:0] len);
    return {err, 7'h0, op, 12'h0, len};
  endfunction

  task automatic push(input logic [31:0] w, input logic last, input logic rc, input string tag);
    q_word.push_back(w); q_last.push_back(last); q_rc.push_back(rc); q_tag.push_back(tag);
  endtask

  task automatic issue(input logic [7:0] op, input logic [1:0] argc,
                       input logic [31:0] a0, input logic [31:0] a1);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_argc = argc; cmd_arg0 = a0; cmd_arg1 = a1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (q_word.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic status(input string tag);
    push(hdr(1'b0, 8'h5B, 4'd9), 1'b0, 1'b0, {tag, " header"});
    push(32'h0, 0, 0, {tag, " w0"});
    push(m_cur, 0, 0, {tag, " w1 current"});
    push(32'h0, 0, 0, {tag, " w2"});
    push(m_fail, 0, 0, {tag, " w3 failing"});
    push(m_code, 0, 0, {tag, " w4 code"});
    push(VER, 0, 0, {tag, " w5 version"});
    push(m_loc, 0, 0, {tag, " w6 loc"});
    push(m_det, 0, 0, {tag, " w7 detail"});
    push({30'h0, m_retry}, 1, 0, {tag, " w8 retry"});
    issue(8'h5B, 2'd0, 32'h0, 32'h0);
  endtask

  task automatic update(input logic [1:0] argc, input logic [31:0] a0, input logic [31:0] a1);
    logic [31:0] t;
    t = (argc != 0) ? a0 : 32'h0;
    if (argc[1] && a1 != 0) begin
      push(hdr(1'b1, 8'h5C, 4'd0), 1, 0, "R9 update reserved high word");
    end else begin
      m_tgt = t;
      push(hdr(1'b0, 8'h5C, 4'd0), 1, 1, "R3 update header");
      m_pend = 1;
    end
    issue(8'h5C, argc, a0, a1);
  endtask

  task automatic notify(input logic [31:0] a);
    if (a == 32'h0005_0000) begin
      m_retry = 0; m_fb = 0;
      push(hdr(1'b0, 8'h5D, 4'd0), 1, 0, "R7 notify retry clear");
    end else if (a == 32'h0006_0000) begin
      m_fail = 0; m_code = 0; m_loc = 0; m_det = 0;
      push(hdr(1'b0, 8'h5D, 4'd0), 1, 0, "R8 notify error clear");
    end else begin
      push(hdr(1'b1, 8'h5D, 4'd0), 1, 0, "R9 notify reserved");
    end
    issue(8'h5D, 2'd1, a, 32'h0);
  endtask

  task automatic ev_ok();
    @(negedge clk); cfg_ok = 1'b1;
    @(negedge clk); cfg_ok = 1'b0;
    if (m_pend) begin
      m_cur = m_tgt; m_fail = 0; m_code = 0; m_loc = 0; m_det = 0;
      m_retry = 0; m_fb = 0; m_pend = 0;
    end
  endtask

  task automatic ev_fail(input logic [31:0] c, input logic [31:0] l, input logic [31:0] d);
    @(negedge clk); cfg_fail = 1'b1; cfg_code = c; cfg_loc = l; cfg_detail = d;
    @(negedge clk); cfg_fail = 1'b0;
    if (m_fail == 0) begin
      m_fail = m_cur; m_code = c; m_loc = l; m_det = d;
    end
  endtask

  task automatic ev_retry();
    @(negedge clk); cfg_retry = 1'b1;
    @(negedge clk); cfg_retry = 1'b0;
    if (m_retry >= 2'(MR - 1)) m_fb = 1;
    else m_retry = m_retry + 1;
  endtask

  int rdy_cnt = 0;
  always @(negedge clk) begin
    rdy_cnt++;
    rsp_ready <= (rdy_cnt % 3) != 1;
  end

  initial begin
    logic stall_prev;
    stall_prev = 0;
    forever begin
      @(negedge clk); #1;
      if (mon_on) begin
        if (rc_due) begin
          chk(reconfig_req == 1'b1, "R3 reconfig pulse", {31'h0, reconfig_req}, 32'h1);
          chk(reconfig_addr == m_tgt, "R3 reconfig address", reconfig_addr, m_tgt);
          rc_due = 0;
        end else if (reconfig_req) begin
          chk(1'b0, "R3/R9 unexpected reconfig pulse", 32'h1, 32'h0);
        end
        if (stall_prev) chk(rsp_valid, "R10 stalled word held", {31'h0, rsp_valid}, 32'h1);
        stall_prev = rsp_valid && !rsp_ready;
        if (rsp_valid) chk(!cmd_ready, "R10 cmd_ready low while busy", {31'h0, cmd_ready}, 32'h0);
        if (rsp_valid && rsp_ready) begin
          if (q_word.size() == 0) begin
            chk(1'b0, "R2 unexpected response word", rsp_word, 32'h0);
          end else begin
            logic [31:0] w; logic l, r; string t;
            w = q_word.pop_front(); l = q_last.pop_front(); r = q_rc.pop_front(); t = q_tag.pop_front();
            chk(rsp_word == w, t, rsp_word, w);
            chk(rsp_last == l, {t, " last flag"}, {31'h0, rsp_last}, {31'h0, l});
            if (r && l) rc_due = 1;
          end
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cmd_ready == 1'b1, "R1 cmd_ready after reset", {31'h0, cmd_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    chk(fallback_req == 1'b0, "R1 fallback after reset", {31'h0, fallback_req}, 32'h0);
    chk(reconfig_req == 1'b0, "R1 reconfig after reset", {31'h0, reconfig_req}, 32'h0);
    mon_on = 1;
    status("R1 R2 reset status");

    update(2'd2, 32'h0010_0000, 32'h0);
    ev_ok();
    status("R4 after update boot");

    ev_fail(32'h0003_0007, 32'h0000_0011, 32'h0000_0022);
    ev_fail(32'h0009_0009, 32'h0000_0033, 32'h0000_0044);
    status("R5 first failure kept");

    ev_ok();
    status("R4 plain boot keeps record");

    ev_retry(); ev_retry();
    @(negedge clk); #1;
    chk(fallback_req == 1'b0, "R6 no fallback below limit", {31'h0, fallback_req}, 32'h0);
    ev_retry();
    @(negedge clk); #1;
    chk(fallback_req == 1'b1, "R6 fallback at limit", {31'h0, fallback_req}, 32'h1);
    status("R6 retry held at limit");

    notify(32'h0005_0000);
    @(negedge clk); #1;
    chk(fallback_req == m_fb, "R7 fallback cleared", {31'h0, fallback_req}, {31'h0, m_fb});
    status("R7 after retry clear");

    ev_retry();
    notify(32'h0006_0000);
    status("R8 after error clear");

    ev_fail(32'h0001_0002, 32'h0000_0055, 32'h0000_0066);
    notify(32'h0001_2345);
    push(hdr(1'b1, 8'h5D, 4'd0), 1, 0, "R9 notify without argument");
    issue(8'h5D, 2'd0, 32'h0006_0000, 32'h0);
    push(hdr(1'b1, 8'h77, 4'd0), 1, 0, "R9 unknown opcode");
    issue(8'h77, 2'd1, 32'h0005_0000, 32'h0);
    update(2'd2, 32'h0020_0000, 32'h0000_0001);
    ev_ok();
    status("R9 state unchanged");

    update(2'd2, 32'h0030_0000, 32'h0);
    ev_ok();
    status("R4 update boot clears record");

    update(2'd0, 32'h0040_0000, 32'h0);
    ev_ok();
    status("R3 missing argument is zero");

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule